// File: doc/BRIEF.md
# Three-Phase Gate Output Arbiter with Zero-Vector Braking

This block is the last stage of a three-phase gate-drive controller. It takes one high-side request and one low-side request per phase and produces the six gate enables that go to the power stage. On the way it applies three overrides, strongest first. A global shutdown turns every gate off. DC-bus overvoltage braking then applies the zero vector: every low side is on and every high side is off, so the motor windings are shorted to the lower rail. The weakest override is a per-phase high-side supply undervoltage, which blocks only that phase's high-side gate.

Two comparator bits report the DC bus. One is set above the upper threshold and one is set below the lower threshold. Each bit passes through its own glitch filter. A filtered level change is accepted only after the raw bit has held the new level for `FILT_LEN` consecutive clock samples. Braking begins once the filtered upper-threshold bit has held for `ENTRY_DLY` further cycles. It ends once the filtered lower-threshold bit has held for `EXIT_DLY` cycles. Braking is not latched, and the gap between the two thresholds gives hysteresis. The block has no fault output, so braking can never signal a fault. A phase whose high-side supply has recovered stays blocked until its high-side request rises again.

All gate outputs are combinational. They depend on the current requests, `shutdown` and `hs_uv`, on the registered braking state and on the per-phase re-arm state. `brake_active` is high exactly while the zero vector is applied.

Top module: `gate_out_arbiter`

## Requirements
- R1: During reset and after reset, with all inputs low, all six gate enables are 0 and `brake_active` is 0.
- R2: With no override active and a high side that is armed, `hs_gate[p]` equals `hs_req[p]` and `ls_gate[p]` equals `ls_req[p]` in the same cycle. Bit p is phase p for p = 0..2.
- R3: While braking is engaged and `shutdown` is low, `hs_gate` = 3'b000, `ls_gate` = 3'b111 and `brake_active` = 1, whatever the requests are, and also when all requests are 0.
- R4: When `bus_over` rises and stays high, the zero vector appears after the clock edge at which the input has been sampled high for `FILT_LEN` + `ENTRY_DLY` consecutive edges, and not before.
- R5: A pulse on `bus_over` or `bus_under` that lasts fewer than `FILT_LEN` consecutive samples neither starts nor ends braking.
- R6: Braking is not latched, but a fall of `bus_over` alone does not release it. It releases after the edge at which `bus_under` has been sampled high for `FILT_LEN` + `EXIT_DLY` consecutive edges.
- R7: While `shutdown` is 1, all six gate enables are 0 and `brake_active` is 0, including while braking is engaged.
- R8: While `hs_uv[p]` is 1, `hs_gate[p]` is 0. The other phases and `ls_gate[p]` are unaffected.
- R9: After `hs_uv[p]` falls, `hs_gate[p]` stays 0 while `hs_req[p]` stays high. It follows the request again from the first cycle in which `hs_req[p]` is sampled high after having been low at the previous clock edge.
- R10: A shutdown does not clear the braking state. If the bus has not dropped below the lower threshold, the zero vector is applied again as soon as `shutdown` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_req | input | 3 | High-side drive requests, bit p = phase p |
| ls_req | input | 3 | Low-side drive requests, bit p = phase p |
| bus_over | input | 1 | DC bus above upper threshold (raw comparator) |
| bus_under | input | 1 | DC bus below lower threshold (raw comparator) |
| shutdown | input | 1 | Global shutdown, forces all gates off |
| hs_uv | input | 3 | Per-phase high-side supply undervoltage |
| hs_gate | output | 3 | High-side gate enables |
| ls_gate | output | 3 | Low-side gate enables |
| brake_active | output | 1 | High while the zero vector is applied |

## Verification
The bench counts the exact edge at which braking starts and ends. An off-by-one in the filter or in the delay counters would move the zero vector by one cycle and be caught. It sends comparator pulses one sample shorter than the filter window, and it drops `bus_over` without raising `bus_under`. A design without filtering or without hysteresis would brake on the glitch or release too early. It asserts shutdown during braking and then releases it. A design that gave braking priority, or that cleared the braking state, would show gates on or lose the zero vector. It clears a high-side undervoltage while the request is held high. A design that re-armed on the level rather than on a fresh rising edge would turn the high side back on at once.

// File: rtl/gate_arb_pkg.sv
package gate_arb_pkg;
  localparam int unsigned PHASES = 3;

  typedef struct packed {
    logic [PHASES-1:0] hs;
    logic [PHASES-1:0] ls;
    logic              brk;
  } gate_set_t;

  // Priority resolution: shutdown, then zero vector, then per-phase requests
  function automatic gate_set_t resolve_gates(input logic sd, input logic brk,
                                              input logic [PHASES-1:0] hs_ok,
                                              input logic [PHASES-1:0] ls_rq);
    gate_set_t g;
    if (sd) begin
      g.hs = '0; g.ls = '0; g.brk = 1'b0;
    end else if (brk) begin
      g.hs = '0; g.ls = '1; g.brk = 1'b1;
    end else begin
      g.hs = hs_ok; g.ls = ls_rq; g.brk = 1'b0;
    end
    return g;
  endfunction

  // Width of a counter that must hold values 0..lim-1
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim > 1) ? $clog2(lim) : 1;
  endfunction
endpackage

// File: rtl/sense_filter.sv
module sense_filter #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  import gate_arb_pkg::*;
  localparam int unsigned CW = cnt_width(LEN);

  logic [CW-1:0] run_q;
  logic          differ_w;
  logic          settle_w;

  assign differ_w = raw ^ filt;
  assign settle_w = differ_w && (run_q == CW'(LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt  <= 1'b0;
      run_q <= '0;
    end else if (!differ_w) begin
      run_q <= '0;
    end else if (settle_w) begin
      filt  <= raw;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  // R5
  filt_only_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> $past(settle_w));

  // R5
  filt_follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> (filt == $past(raw)));
endmodule

// File: rtl/brake_fsm.sv
module brake_fsm #(
  parameter int unsigned ENTRY_DLY = 4,
  parameter int unsigned EXIT_DLY  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic over_f,
  input  logic under_f,
  output logic brake_q
);
  import gate_arb_pkg::*;
  localparam int unsigned MAXD = (ENTRY_DLY > EXIT_DLY) ? ENTRY_DLY : EXIT_DLY;
  localparam int unsigned CW   = cnt_width(MAXD);

  logic [CW-1:0] dly_q;
  logic          cond_w;
  logic          done_w;

  assign cond_w = brake_q ? under_f : over_f;
  assign done_w = cond_w && (dly_q == (brake_q ? CW'(EXIT_DLY - 1) : CW'(ENTRY_DLY - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brake_q <= 1'b0;
      dly_q   <= '0;
    end else if (!cond_w) begin
      dly_q <= '0;
    end else if (done_w) begin
      brake_q <= ~brake_q;
      dly_q   <= '0;
    end else begin
      dly_q <= dly_q + 1'b1;
    end
  end

  // R4
  entry_needs_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brake_q) |-> $past(over_f));

  // R6
  exit_needs_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brake_q) |-> $past(under_f));
endmodule

// File: rtl/hs_rearm.sv
module hs_rearm (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic uv,
  output logic en
);
  logic armed_q;
  logic req_d_q;
  logic rise_w;

  assign rise_w = req && !req_d_q;
  assign en     = req && !uv && (armed_q || rise_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      req_d_q <= 1'b0;
    end else begin
      armed_q <= !uv && (armed_q || rise_w);
      req_d_q <= req;
    end
  end

  // R9
  rearm_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> rise_w);

  // R9
  held_req_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(uv) && $past(req) && req) |-> !en);
endmodule

// File: rtl/gate_out_arbiter.sv
module gate_out_arbiter #(
  parameter int unsigned FILT_LEN  = 16,
  parameter int unsigned ENTRY_DLY = 4,
  parameter int unsigned EXIT_DLY  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hs_req,
  input  logic [2:0] ls_req,
  input  logic       bus_over,
  input  logic       bus_under,
  input  logic       shutdown,
  input  logic [2:0] hs_uv,
  output logic [2:0] hs_gate,
  output logic [2:0] ls_gate,
  output logic       brake_active
);
  import gate_arb_pkg::*;

  logic              over_f;
  logic              under_f;
  logic              brake_q;
  logic [PHASES-1:0] hs_ok;
  gate_set_t         gates_w;

  sense_filter #(.LEN(FILT_LEN)) over_filt_i (
    .clk(clk), .rst_n(rst_n), .raw(bus_over), .filt(over_f));

  sense_filter #(.LEN(FILT_LEN)) under_filt_i (
    .clk(clk), .rst_n(rst_n), .raw(bus_under), .filt(under_f));

  brake_fsm #(.ENTRY_DLY(ENTRY_DLY), .EXIT_DLY(EXIT_DLY)) brake_i (
    .clk(clk), .rst_n(rst_n), .over_f(over_f), .under_f(under_f), .brake_q(brake_q));

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    hs_rearm rearm_i (
      .clk(clk), .rst_n(rst_n), .req(hs_req[p]), .uv(hs_uv[p]), .en(hs_ok[p]));
  end

  assign gates_w      = resolve_gates(shutdown, brake_q, hs_ok, ls_req);
  assign hs_gate      = gates_w.hs;
  assign ls_gate      = gates_w.ls;
  assign brake_active = gates_w.brk;

  // R7
  shutdown_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (hs_gate == 3'b000 && ls_gate == 3'b000 && !brake_active));

  // R3
  zero_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brake_active |-> (hs_gate == 3'b000 && ls_gate == 3'b111));

  // R8
  ls_unaffected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && !brake_active) |-> (ls_gate == ls_req));

  // R8
  uv_blocks_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hs_gate & hs_uv) == 3'b000));
endmodule

// File: tb/gate_out_arbiter_tb_top.sv
module gate_out_arbiter_tb_top;
  localparam int F = 4;
  localparam int E = 2;
  localparam int X = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hs_req = '0, ls_req = '0, hs_uv = '0;
  logic       bus_over = 1'b0, bus_under = 1'b0, shutdown = 1'b0;
  logic [2:0] hs_gate, ls_gate;
  logic       brake_active;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [6:0] exp_q[$];
  string      tag_q[$];

  // reference state, kept from the requirements
  int   m_ro, m_ru, m_bc;
  bit   m_fo, m_fu, m_brk;
  bit [2:0] m_arm, m_prev;

  always #2 clk = ~clk;

  gate_out_arbiter #(.FILT_LEN(F), .ENTRY_DLY(E), .EXIT_DLY(X)) dut_i (
    .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ls_req(ls_req),
    .bus_over(bus_over), .bus_under(bus_under), .shutdown(shutdown),
    .hs_uv(hs_uv), .hs_gate(hs_gate), .ls_gate(ls_gate),
    .brake_active(brake_active));

  function automatic logic [6:0] predict();
    logic [2:0] ok;
    for (int p = 0; p < 3; p++)
      ok[p] = hs_req[p] && !hs_uv[p] && (m_arm[p] || !m_prev[p]);
    if (!rst_n) ok = '0;
    if (shutdown) return 7'b0;
    if (m_brk) return {3'b000, 3'b111, 1'b1};
    return {ok, ls_req, 1'b0};
  endfunction

  task automatic model_edge();
    if (!rst_n) begin
      m_ro = 0; m_ru = 0; m_bc = 0; m_fo = 0; m_fu = 0; m_brk = 0;
      m_arm = '0; m_prev = '0;
      return;
    end
    // braking state uses the filtered values held before this edge
    if ((m_brk ? m_fu : m_fo)) begin
      if (m_bc == (m_brk ? X : E) - 1) begin m_brk = !m_brk; m_bc = 0; end
      else m_bc++;
    end else m_bc = 0;
    if (bus_over == m_fo) m_ro = 0;
    else if (m_ro == F - 1) begin m_fo = bus_over; m_ro = 0; end
    else m_ro++;
    if (bus_under == m_fu) m_ru = 0;
    else if (m_ru == F - 1) begin m_fu = bus_under; m_ru = 0; end
    else m_ru++;
    for (int p = 0; p < 3; p++) begin
      m_arm[p]  = !hs_uv[p] && (m_arm[p] || (hs_req[p] && !m_prev[p]));
      m_prev[p] = hs_req[p];
    end
  endtask

  task automatic run(input logic [2:0] hs, input logic [2:0] ls, input logic ov,
                     input logic un, input logic sd, input logic [2:0] uv,
                     input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hs_req = hs; ls_req = ls; bus_over = ov; bus_under = un;
      shutdown = sd; hs_uv = uv;
      exp_q.push_back(predict());
      tag_q.push_back(tag);
      @(posedge clk);
      model_edge();
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        logic [6:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if ({hs_gate, ls_gate, brake_active} !== e) begin
          bad++;
          $display("FAIL %s: got hs=%b ls=%b brk=%b expected hs=%b ls=%b brk=%b",
                   t, hs_gate, ls_gate, brake_active, e[6:4], e[3:1], e[0]);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    rst_n = 1'b0;
    run(3'b000, 3'b000, 0, 0, 0, 3'b000, 4, "R1");
    @(negedge clk); rst_n = 1'b1;
    run(3'b000, 3'b000, 0, 0, 0, 3'b000, 3, "R1");
    // R2 pass-through patterns
    run(3'b101, 3'b010, 0, 0, 0, 3'b000, 3, "R2");
    run(3'b010, 3'b101, 0, 0, 0, 3'b000, 3, "R2");
    run(3'b000, 3'b000, 0, 0, 0, 3'b000, 2, "R2");
    run(3'b111, 3'b000, 0, 0, 0, 3'b000, 3, "R2");
    // R5 short over pulse ignored
    run(3'b111, 3'b000, 1, 0, 0, 3'b000, F - 1, "R5");
    run(3'b111, 3'b000, 0, 0, 0, 3'b000, 6, "R5");
    // R4 entry timing, then R3 zero vector with several request patterns
    run(3'b111, 3'b000, 1, 0, 0, 3'b000, F + E + 2, "R4");
    run(3'b000, 3'b000, 1, 0, 0, 3'b000, 3, "R3");
    run(3'b111, 3'b111, 1, 0, 0, 3'b000, 3, "R3");
    // R6 over falling alone does not release
    run(3'b101, 3'b010, 0, 0, 0, 3'b000, 8, "R6");
    // R5 short under pulse does not release
    run(3'b101, 3'b010, 0, 1, 0, 3'b000, F - 1, "R5");
    run(3'b101, 3'b010, 0, 0, 0, 3'b000, 4, "R5");
    // R6 release after filter plus exit delay
    run(3'b101, 3'b010, 0, 1, 0, 3'b000, F + X + 3, "R6");
    run(3'b101, 3'b010, 0, 0, 0, 3'b000, 3, "R6");
    // R7 shutdown in normal operation
    run(3'b111, 3'b111, 0, 0, 1, 3'b000, 3, "R7");
    run(3'b000, 3'b000, 0, 0, 0, 3'b000, 2, "R7");
    // R7 / R10 shutdown during braking keeps braking state
    run(3'b010, 3'b001, 1, 0, 0, 3'b000, F + E + 1, "R4");
    run(3'b010, 3'b001, 0, 0, 1, 3'b000, 4, "R7");
    run(3'b010, 3'b001, 0, 0, 0, 3'b000, 3, "R10");
    run(3'b010, 3'b001, 0, 1, 0, 3'b000, F + X + 2, "R6");
    run(3'b000, 3'b000, 0, 0, 0, 3'b000, 2, "R6");
    // R8 high-side undervoltage on phase 1
    run(3'b111, 3'b111, 0, 0, 0, 3'b000, 2, "R8");
    run(3'b111, 3'b111, 0, 0, 0, 3'b010, 3, "R8");
    run(3'b111, 3'b011, 0, 0, 0, 3'b110, 3, "R8");
    // R9 recovery with request held high stays off, then fresh edge re-arms
    run(3'b111, 3'b000, 0, 0, 0, 3'b000, 3, "R9");
    run(3'b101, 3'b000, 0, 0, 0, 3'b000, 2, "R9");
    run(3'b111, 3'b000, 0, 0, 0, 3'b000, 3, "R9");
    @(negedge clk);
    @(negedge clk);
    #2;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule